// File: doc/BRIEF.md
# Multichannel Shadowed PWM Generator

This block drives a bank of pulse-width-modulated outputs from one clock. Every channel has a period, a high time and a start delay. Software programs these values through a 32-bit, word-addressed register port. The port also serves identification words, a scratch word, a control word and a readback of the channel count. Channel writes land in shadow copies. The counters keep running on the active copies until software asks for a load. The load is carried out at the end of the period that channel 0 is running. At that moment every channel takes its new values and restarts in the same clock, so the bank stays phase-aligned.

Each restarted channel first stays low for its start delay. After that it repeats a pattern: high for its high time at the start of each period, then low for the rest. A hold bit in the control word freezes the whole bank with every output low. Clearing the hold bit restarts all channels together.

The sequencing is a three-state machine:

- `ST_RUN`: normal counting.
- `ST_ARMED`: a load has been requested and is waiting for channel 0's period boundary.
- `ST_HOLD`: the bank is frozen.

Its transitions are:

- **arm** (`ST_RUN`→`ST_ARMED`): a control write with the load bit set.
- **commit** (`ST_ARMED`→`ST_RUN`): the boundary is reached. The shadow copies become active and all channels restart.
- **freeze** (any state→`ST_HOLD`): a control write with the hold bit set.
- **release** (`ST_HOLD`→`ST_RUN`): a control write with the hold bit clear. All channels restart.

Each channel has its own phase machine:

- `PH_IDLE`: held.
- `PH_DELAY`: counting the start delay.
- `PH_CYCLE`: producing the waveform.

Top module: `pwm_bank`

## Requirements
- R1: After `rst_n` is released, every output is low, the control word reads 0, and every shadow channel field reads 0.
- R2: The following words are read-only, and writes to them are ignored:
  - word 0x00 reads {8'h00, major, minor, patch} (bits 23:16, 15:8, 7:0), which is 0x00010000 by default;
  - word 0x04 reads the `CORE_ID` parameter (default 0x50570001);
  - word 0x0C reads 0x601A3471;
  - word 0x14 reads the channel count.
- R3: Word 0x08 is a 32-bit read/write scratch word.
- R4: A read request (`req_valid`=1, `req_write`=0) returns `rsp_valid`=1 with its data in the next cycle. `req_ready` is always 1. An unmapped address reads 0. An address whose bits 1:0 are not 00 reads 0, and a write to it is ignored.
- R5: Channel c has its period at 0x40+12c, its high time at 0x44+12c and its start delay at 0x48+12c. Writes keep bits CNT_W-1:0 (16 by default) and read back zero-extended. They change only the shadow copy, and the outputs are unaffected.
- R6: A control write (word 0x10) with bit 1 set, outside hold, arms a load. The load commits at the clock edge that ends the cycle in which channel 0's count is at period−1. If channel 0 is in its delay or has period 0, it commits at the next edge. Bit 1 always reads 0.
- R7: A commit restarts every channel at the same edge with the new values. A shadow write that falls in the commit cycle is not part of that commit.
- R8: After a restart, a channel stays low for its start-delay clocks. It then repeats its pattern: high while its count is below the high time, for a count that runs from 0 to period−1.
- R9: A channel with period 0 stays low. A channel with high time ≥ period stays high once its delay has passed.
- R10: A control write with bit 0 set drives all outputs low from the next cycle and holds the counters, and the control word then reads 1. A control write with bit 0 clear releases the hold and restarts all channels from their start delays at the next edge.
- R11: A load bit written during hold, or together with the hold bit, copies shadow to active at once, without waiting for a boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 32 | Read data |
| pwm_o | output | NCH | Channel outputs |

## Verification
Two events can land on the same clock edge, and the bench arranges both on purpose. The first is a commit together with a bus write to a shadow field. The bench watches its reference model and issues the write in exactly the cycle where channel 0 sits at period−1 while a load is armed. It then checks that the outputs follow the old shadow value and that the new value only shows in the readback. The second is a load bit written during hold or together with the hold bit. The bench judges this after release, by comparing every output on every clock against the model.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_ARMED = 2'd1,
        ST_HOLD  = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_DELAY = 2'd1,
        PH_CYCLE = 2'd2
    } chan_phase_e;

    localparam logic [31:0] MAGIC_WORD = 32'h601A3471;

    localparam int CFG_HOLD_BIT = 0;
    localparam int CFG_LOAD_BIT = 1;

    // word indices (byte address / 4)
    localparam int W_VERSION     = 0;
    localparam int W_IDENT       = 1;
    localparam int W_SCRATCH     = 2;
    localparam int W_MAGIC       = 3;
    localparam int W_CONTROL     = 4;
    localparam int W_COUNT       = 5;
    localparam int W_CHAN_BASE   = 16;
    localparam int W_CHAN_STRIDE = 3;

endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
    import pwm_bank_pkg::*;
#(
    parameter int          NCH       = 4,
    parameter int          CNT_W     = 16,
    parameter int          ADDR_W    = 8,
    parameter logic [7:0]  VER_MAJOR = 8'd1,
    parameter logic [7:0]  VER_MINOR = 8'd0,
    parameter logic [7:0]  VER_PATCH = 8'd0,
    parameter logic [31:0] CORE_ID   = 32'h5057_0001
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_valid,
    input  logic                           req_write,
    input  logic [ADDR_W-1:0]              req_addr,
    input  logic [31:0]                    req_wdata,
    output logic                           rsp_valid,
    output logic [31:0]                    rsp_rdata,
    input  logic                           commit_i,
    input  logic                           held_i,
    output logic                           cfg_wr_o,
    output logic                           cfg_hold_o,
    output logic                           cfg_load_o,
    output logic [NCH-1:0][CNT_W-1:0]      act_per_o,
    output logic [NCH-1:0][CNT_W-1:0]      act_duty_o,
    output logic [NCH-1:0][CNT_W-1:0]      act_off_o,
    output logic [NCH-1:0][CNT_W-1:0]      next_off_o
);

    localparam int WORD_W = ADDR_W - 2;

    function automatic logic [WORD_W-1:0] chan_word(input int ch, input int sel);
        return WORD_W'(W_CHAN_BASE + W_CHAN_STRIDE * ch + sel);
    endfunction

    logic [WORD_W-1:0] word;
    logic              aligned;
    logic              wr_en;
    logic              rd_en;
    logic [31:0]       rd_word;
    logic [31:0]       scratch_q;

    logic [NCH-1:0][CNT_W-1:0] sh_per, sh_duty, sh_off;
    logic [NCH-1:0][CNT_W-1:0] ac_per, ac_duty, ac_off;

    assign word    = req_addr[ADDR_W-1:2];
    assign aligned = (req_addr[1:0] == 2'b00);
    assign wr_en   = req_valid && req_write && aligned;
    assign rd_en   = req_valid && !req_write;

    assign cfg_wr_o   = wr_en && (word == WORD_W'(W_CONTROL));
    assign cfg_hold_o = req_wdata[CFG_HOLD_BIT];
    assign cfg_load_o = req_wdata[CFG_LOAD_BIT];

    // shadow and scratch storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scratch_q <= '0;
            sh_per    <= '0;
            sh_duty   <= '0;
            sh_off    <= '0;
        end else if (wr_en) begin
            if (word == WORD_W'(W_SCRATCH))
                scratch_q <= req_wdata;
            for (int i = 0; i < NCH; i++) begin
                if (word == chan_word(i, 0)) sh_per[i]  <= req_wdata[CNT_W-1:0];
                if (word == chan_word(i, 1)) sh_duty[i] <= req_wdata[CNT_W-1:0];
                if (word == chan_word(i, 2)) sh_off[i]  <= req_wdata[CNT_W-1:0];
            end
        end
    end

    // active copies follow shadow only on commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ac_per  <= '0;
            ac_duty <= '0;
            ac_off  <= '0;
        end else if (commit_i) begin
            ac_per  <= sh_per;
            ac_duty <= sh_duty;
            ac_off  <= sh_off;
        end
    end

    always_comb begin
        for (int i = 0; i < NCH; i++)
            next_off_o[i] = commit_i ? sh_off[i] : ac_off[i];
    end

    assign act_per_o  = ac_per;
    assign act_duty_o = ac_duty;
    assign act_off_o  = ac_off;

    // read decode
    always_comb begin
        rd_word = '0;
        if (aligned) begin
            case (word)
                WORD_W'(W_VERSION): rd_word = {8'h00, VER_MAJOR, VER_MINOR, VER_PATCH};
                WORD_W'(W_IDENT):   rd_word = CORE_ID;
                WORD_W'(W_SCRATCH): rd_word = scratch_q;
                WORD_W'(W_MAGIC):   rd_word = MAGIC_WORD;
                WORD_W'(W_CONTROL): rd_word = 32'(held_i);
                WORD_W'(W_COUNT):   rd_word = 32'(NCH);
                default: begin
                    for (int i = 0; i < NCH; i++) begin
                        if (word == chan_word(i, 0)) rd_word = 32'(sh_per[i]);
                        if (word == chan_word(i, 1)) rd_word = 32'(sh_duty[i]);
                        if (word == chan_word(i, 2)) rd_word = 32'(sh_off[i]);
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_en;
            if (rd_en)
                rsp_rdata <= rd_word;
        end
    end

    AST_ACTIVE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> ($stable(ac_per) && $stable(ac_duty) && $stable(ac_off))); // R5
    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid); // R4
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid); // R4

endmodule

// File: rtl/pwm_bank_seq.sv
module pwm_bank_seq
    import pwm_bank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr_i,
    input  logic cfg_hold_i,
    input  logic cfg_load_i,
    input  logic bound_i,
    output logic commit_o,
    output logic sync_o,
    output logic halt_o,
    output logic held_o
);

    seq_state_e state_q, state_nx;
    logic       commit_nx, sync_nx;

    // next state and strobes
    always_comb begin
        state_nx  = state_q;
        commit_nx = 1'b0;
        sync_nx   = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (cfg_wr_i && cfg_hold_i) begin
                    state_nx  = ST_HOLD;
                    commit_nx = cfg_load_i;
                end else if (cfg_wr_i && cfg_load_i) begin
                    state_nx  = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (cfg_wr_i && cfg_hold_i) begin
                    state_nx  = ST_HOLD;
                    commit_nx = cfg_load_i;
                end else if (bound_i) begin
                    state_nx  = ST_RUN;
                    commit_nx = 1'b1;
                    sync_nx   = 1'b1;
                end
            end
            ST_HOLD: begin
                if (cfg_wr_i && cfg_hold_i) begin
                    commit_nx = cfg_load_i;
                end else if (cfg_wr_i) begin
                    state_nx  = ST_RUN;
                    sync_nx   = 1'b1;
                    commit_nx = cfg_load_i;
                end
            end
            default: state_nx = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_nx;
    end

    // outputs
    always_comb begin
        commit_o = commit_nx;
        sync_o   = sync_nx;
        halt_o   = (state_nx == ST_HOLD);
        held_o   = (state_q == ST_HOLD);
    end

    AST_ARMED_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && !bound_i && !cfg_wr_i) |=> (state_q == ST_ARMED)); // R6
    AST_HOLD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !cfg_wr_i) |=> (state_q == ST_HOLD)); // R10
    AST_HOLD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_i && cfg_hold_i) |=> held_o); // R10

endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
    import pwm_bank_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter bit IS_REF = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt_i,
    input  logic             sync_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] duty_i,
    input  logic [CNT_W-1:0] offset_i,
    input  logic [CNT_W-1:0] sync_off_i,
    output logic             wave_o,
    output logic             bound_o
);

    chan_phase_e      ph_q, ph_nx;
    logic [CNT_W-1:0] cnt_q, cnt_nx;
    logic [CNT_W-1:0] per_last, off_last;

    assign per_last = period_i - 1'b1;
    assign off_last = offset_i - 1'b1;

    always_comb begin
        ph_nx  = ph_q;
        cnt_nx = cnt_q;
        if (sync_i) begin
            cnt_nx = '0;
            ph_nx  = (sync_off_i == '0) ? PH_CYCLE : PH_DELAY;
        end else if (halt_i) begin
            cnt_nx = '0;
            ph_nx  = PH_IDLE;
        end else begin
            unique case (ph_q)
                PH_IDLE: cnt_nx = '0;
                PH_DELAY: begin
                    if (offset_i == '0 || cnt_q >= off_last) begin
                        ph_nx  = PH_CYCLE;
                        cnt_nx = '0;
                    end else begin
                        cnt_nx = cnt_q + 1'b1;
                    end
                end
                PH_CYCLE: begin
                    if (period_i == '0 || cnt_q >= per_last) cnt_nx = '0;
                    else                                     cnt_nx = cnt_q + 1'b1;
                end
                default: begin
                    ph_nx  = PH_IDLE;
                    cnt_nx = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_CYCLE;
            cnt_q <= '0;
        end else begin
            ph_q  <= ph_nx;
            cnt_q <= cnt_nx;
        end
    end

    always_comb begin
        wave_o  = (ph_q == PH_CYCLE) && (period_i != '0) && (cnt_q < duty_i);
        bound_o = IS_REF && ((ph_q != PH_CYCLE) || (period_i == '0) || (cnt_q >= per_last));
    end

    AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_CYCLE && period_i != '0) |-> (cnt_q < period_i)); // R8
    AST_DELAY_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_DELAY) |-> (cnt_q < offset_i)); // R8
    AST_HALT_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_i && !sync_i) |=> (ph_q == PH_IDLE)); // R10
    AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> (cnt_q == '0)); // R7

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int          NCH       = 4,
    parameter int          CNT_W     = 16,
    parameter int          ADDR_W    = 8,
    parameter logic [7:0]  VER_MAJOR = 8'd1,
    parameter logic [7:0]  VER_MINOR = 8'd0,
    parameter logic [7:0]  VER_PATCH = 8'd0,
    parameter logic [31:0] CORE_ID   = 32'h5057_0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic [NCH-1:0]    pwm_o
);

    localparam int MAP_END = 4 * (W_CHAN_BASE + W_CHAN_STRIDE * NCH);

    logic commit, sync, halt, held;
    logic cfg_wr, cfg_hold, cfg_load;
    logic [NCH-1:0][CNT_W-1:0] act_per, act_duty, act_off, next_off;
    logic [NCH-1:0] chan_wave, chan_bound;

    assign req_ready = 1'b1;

    pwm_bank_regs #(
        .NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W),
        .VER_MAJOR(VER_MAJOR), .VER_MINOR(VER_MINOR), .VER_PATCH(VER_PATCH),
        .CORE_ID(CORE_ID)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .commit_i(commit), .held_i(held),
        .cfg_wr_o(cfg_wr), .cfg_hold_o(cfg_hold), .cfg_load_o(cfg_load),
        .act_per_o(act_per), .act_duty_o(act_duty),
        .act_off_o(act_off), .next_off_o(next_off)
    );

    pwm_bank_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_i(cfg_wr), .cfg_hold_i(cfg_hold), .cfg_load_i(cfg_load),
        .bound_i(|chan_bound),
        .commit_o(commit), .sync_o(sync), .halt_o(halt), .held_o(held)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        pwm_bank_chan #(
            .CNT_W(CNT_W),
            .IS_REF(g == 0)
        ) u_chan (
            .clk(clk), .rst_n(rst_n),
            .halt_i(halt), .sync_i(sync),
            .period_i(act_per[g]), .duty_i(act_duty[g]),
            .offset_i(act_off[g]), .sync_off_i(next_off[g]),
            .wave_o(chan_wave[g]), .bound_o(chan_bound[g])
        );
    end

    assign pwm_o = chan_wave & ~{NCH{held}};

    initial begin
        AST_MAP_FITS: assert (MAP_END <= (1 << ADDR_W)); // R5
    end

    AST_SYNC_NOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        sync |=> !held); // R10

endmodule

// File: tb/pwm_bank_bench.sv
module pwm_bank_bench;

    localparam int NCH = 4;
    localparam int M_RUN = 0, M_ARMED = 1, M_HOLD = 2;
    localparam int unsigned ID_VAL = 32'h5057_0001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bv = 1'b0, bw = 1'b0;
    logic [7:0] ba = '0;
    logic [31:0] bd = '0;
    logic rdy, rv;
    logic [31:0] rd;
    logic [NCH-1:0] pwm;

    always #10 clk = ~clk;

    pwm_bank u_pwm_bank (
        .clk(clk), .rst_n(rst_n),
        .req_valid(bv), .req_ready(rdy), .req_write(bw),
        .req_addr(ba), .req_wdata(bd),
        .rsp_valid(rv), .rsp_rdata(rd), .pwm_o(pwm)
    );

    int checks = 0, errors = 0;
    string tag = "R1";

    // behavioural reference
    int sh_p[NCH], sh_d[NCH], sh_o[NCH], ac_p[NCH], ac_d[NCH], ac_o[NCH];
    int ph[NCH], cnt[NCH];
    int mst;
    int unsigned scratch, e_rd;
    bit e_rv;

    task automatic m_init();
        for (int i = 0; i < NCH; i++) begin
            sh_p[i] = 0; sh_d[i] = 0; sh_o[i] = 0;
            ac_p[i] = 0; ac_d[i] = 0; ac_o[i] = 0;
            ph[i] = 2; cnt[i] = 0;
        end
        mst = M_RUN; scratch = 0; e_rv = 0; e_rd = 0;
    endtask

    function automatic int unsigned m_read(input int a);
        int w;
        if ((a % 4) != 0) return 0;
        w = a / 4;
        case (w)
            0: return 32'h0001_0000;
            1: return ID_VAL;
            2: return scratch;
            3: return 32'h601A3471;
            4: return (mst == M_HOLD) ? 1 : 0;
            5: return NCH;
            default: begin
                if (w >= 16 && w < 16 + 3 * NCH) begin
                    case ((w - 16) % 3)
                        0: return sh_p[(w - 16) / 3];
                        1: return sh_d[(w - 16) / 3];
                        default: return sh_o[(w - 16) / 3];
                    endcase
                end
                return 0;
            end
        endcase
    endfunction

    task automatic m_step();
        int w, ns, noff;
        bit al, wr, cfgw, hb, lb, bnd, cm, sy;
        w = int'(ba) / 4;
        al = (ba[1:0] == 2'b00);
        wr = bv && bw && al;
        cfgw = wr && (w == 4);
        hb = bd[0]; lb = bd[1];
        bnd = (ph[0] != 2) || (ac_p[0] == 0) || (cnt[0] >= ac_p[0] - 1);
        ns = mst; cm = 0; sy = 0;
        case (mst)
            M_RUN:   if (cfgw && hb) begin ns = M_HOLD; cm = lb; end
                     else if (cfgw && lb) ns = M_ARMED;
            M_ARMED: if (cfgw && hb) begin ns = M_HOLD; cm = lb; end
                     else if (bnd) begin ns = M_RUN; cm = 1; sy = 1; end
            default: if (cfgw && hb) cm = lb;
                     else if (cfgw) begin ns = M_RUN; sy = 1; cm = lb; end
        endcase
        e_rv = bv && !bw;
        if (e_rv) e_rd = m_read(int'(ba));
        for (int i = 0; i < NCH; i++) begin
            noff = cm ? sh_o[i] : ac_o[i];
            if (sy) begin
                cnt[i] = 0; ph[i] = (noff == 0) ? 2 : 1;
            end else if (ns == M_HOLD) begin
                cnt[i] = 0; ph[i] = 0;
            end else if (ph[i] == 0) begin
                cnt[i] = 0;
            end else if (ph[i] == 1) begin
                if (ac_o[i] == 0 || cnt[i] >= ac_o[i] - 1) begin ph[i] = 2; cnt[i] = 0; end
                else cnt[i]++;
            end else begin
                if (ac_p[i] == 0 || cnt[i] >= ac_p[i] - 1) cnt[i] = 0;
                else cnt[i]++;
            end
        end
        if (cm) for (int i = 0; i < NCH; i++) begin
            ac_p[i] = sh_p[i]; ac_d[i] = sh_d[i]; ac_o[i] = sh_o[i];
        end
        if (wr) begin
            if (w == 2) scratch = bd;
            if (w >= 16 && w < 16 + 3 * NCH) begin
                case ((w - 16) % 3)
                    0: sh_p[(w - 16) / 3] = int'(bd[15:0]);
                    1: sh_d[(w - 16) / 3] = int'(bd[15:0]);
                    default: sh_o[(w - 16) / 3] = int'(bd[15:0]);
                endcase
            end
        end
        mst = ns;
    endtask

    function automatic logic [NCH-1:0] m_pwm();
        logic [NCH-1:0] v;
        for (int i = 0; i < NCH; i++)
            v[i] = (mst != M_HOLD) && (ph[i] == 2) && (ac_p[i] != 0) && (cnt[i] < ac_d[i]);
        return v;
    endfunction

    task automatic compare();
        logic [NCH-1:0] ep;
        ep = m_pwm();
        checks++;
        if (pwm !== ep) begin
            errors++;
            $display("FAIL %s pwm_o got %b expected %b", tag, pwm, ep);
        end
        checks++;
        if (rv !== e_rv || (e_rv && rd !== e_rd)) begin
            errors++;
            $display("FAIL %s rsp got %b/%h expected %b/%h", tag, rv, rd, e_rv, e_rd);
        end
    endtask

    task automatic cyc(input bit v, input bit w, input int a, input int unsigned d);
        bv = v; bw = w; ba = a[7:0]; bd = d;
        @(posedge clk);
        m_step();
        @(negedge clk);
        compare();
        bv = 1'b0; bw = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc(0, 0, 0, 0);
    endtask

    task automatic wr(input int a, input int unsigned d);
        cyc(1, 1, a, d);
    endtask

    task automatic rd_chk(input int a, input int unsigned exp);
        cyc(1, 0, a, 0);
        checks++;
        if (rd !== exp) begin
            errors++;
            $display("FAIL %s read %h got %h expected %h", tag, a, rd, exp);
        end
    endtask

    task automatic chk_eq(input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s value got %0d expected %0d", tag, got, exp);
        end
    endtask

    // issue a write in the cycle that ends with a commit
    task automatic write_on_commit(input int a, input int unsigned d);
        for (int k = 0; k < 200; k++) begin
            if (mst == M_ARMED && ph[0] == 2 && cnt[0] == ac_p[0] - 1) begin
                wr(a, d);
                return;
            end
            cyc(0, 0, 0, 0);
        end
        chk_eq(0, 1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stimulus
        m_init();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        tag = "R1";
        chk_eq(int'(pwm), 0);
        rst_n = 1'b1;
        rd_chk(8'h10, 0);
        rd_chk(8'h40, 0);
        rd_chk(8'h60, 0);

        tag = "R2";
        rd_chk(8'h00, 32'h0001_0000);
        rd_chk(8'h04, ID_VAL);
        rd_chk(8'h0C, 32'h601A3471);
        rd_chk(8'h14, NCH);
        wr(8'h0C, 32'hFFFF_FFFF);
        rd_chk(8'h0C, 32'h601A3471);
        wr(8'h14, 9);
        rd_chk(8'h14, NCH);

        tag = "R3";
        wr(8'h08, 32'hDEAD_BEEF);
        rd_chk(8'h08, 32'hDEAD_BEEF);
        wr(8'h08, 32'h1234_5678);
        rd_chk(8'h08, 32'h1234_5678);

        tag = "R4";
        chk_eq(int'(rdy), 1);
        rd_chk(8'h18, 0);
        rd_chk(8'h09, 0);
        rd_chk(8'hFC, 0);
        wr(8'h0A, 0);
        rd_chk(8'h08, 32'h1234_5678);

        tag = "R5";
        wr(8'h40, 32'hABCD_000A); wr(8'h44, 3); wr(8'h48, 0);
        wr(8'h4C, 6); wr(8'h50, 9); wr(8'h54, 2);
        wr(8'h58, 0); wr(8'h5C, 5); wr(8'h60, 0);
        wr(8'h64, 8); wr(8'h68, 2); wr(8'h6C, 3);
        rd_chk(8'h40, 10);
        rd_chk(8'h50, 9);
        rd_chk(8'h6C, 3);
        idle(10);
        chk_eq(int'(pwm), 0);

        tag = "R6";
        wr(8'h10, 2);
        rd_chk(8'h10, 0);
        idle(30);

        tag = "R9";
        chk_eq(int'(pwm[2]), 0);
        chk_eq(int'(pwm[1]), 1);
        idle(12);

        tag = "R6";
        wr(8'h40, 12); wr(8'h44, 7);
        idle(15);
        wr(8'h10, 2);
        idle(30);

        tag = "R7";
        wr(8'h10, 2);
        write_on_commit(8'h68, 5);
        idle(20);
        rd_chk(8'h68, 5);
        wr(8'h10, 2);
        idle(30);

        tag = "R10";
        wr(8'h10, 1);
        idle(5);
        chk_eq(int'(pwm), 0);
        rd_chk(8'h10, 1);
        wr(8'h54, 0);
        wr(8'h64, 5);

        tag = "R11";
        wr(8'h10, 2);
        tag = "R8";
        wr(8'h10, 0);
        idle(40);

        tag = "R11";
        wr(8'h6C, 4);
        wr(8'h10, 3);
        idle(3);
        wr(8'h6C, 1);
        tag = "R10";
        wr(8'h10, 0);
        idle(40);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule